// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates the address sequence for a four-beat memory burst. A load strobe captures a full starting address. The low bits of that address give the starting offset inside an aligned group of four. Each advance pulse then steps the low bits to the next beat. The upper bits are held as loaded for the whole burst. After the fourth beat the sequence wraps back to the start.

Two step orders are supported, and the order is chosen when the burst is loaded:

- **Linear order** is a wrapping increment of the offset.
- **Interleaved order** XORs the starting offset with a running beat count.

A last-beat flag marks the fourth beat of the burst. A memory controller or cache fill engine would place this block in front of its array address port. It would assert the load input on either of its address strobes and the advance input once per transferred beat.

Top module: `burst_seq_top`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after its release, `addr_o` is all zeros and `last_o` is 0.
- R2: In the cycle after a clock edge with `load_i` = 1, `addr_o` equals the `addr_i` value sampled at that edge and `last_o` is 0.
- R3: With `mode_i` = 0 (linear) at the load, the low two bits of `addr_o` after the n-th advance equal (start + n) mod 4. For example, start 2 gives 2, 3, 0, 1.
- R4: With `mode_i` = 1 (interleaved) at the load, the low two bits of `addr_o` after the n-th advance equal start XOR (n mod 4). For example, start 1 gives 1, 0, 3, 2.
- R5: `mode_i` is sampled only in load cycles. Changing it during a burst does not alter the order of that burst.
- R6: At an edge with `load_i` = 0 and `adv_i` = 0, `addr_o` and `last_o` keep their values.
- R7: When `load_i` and `adv_i` are both 1 at an edge, the load wins. The advance is ignored, and the burst restarts at the new address with `last_o` = 0.
- R8: `last_o` is 1 exactly when three advances have occurred since the load. A fourth advance returns `addr_o` to the starting address and clears `last_o`.
- R9: The bits of `addr_o` above the low two keep the loaded value until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Starts a new burst at `addr_i` |
| adv_i | input | 1 | Steps to the next beat |
| mode_i | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | Starting address of the burst |
| addr_o | output | ADDR_W | Current burst address |
| last_o | output | 1 | High on the fourth beat of the burst |

## Verification
The bench builds the block with `ADDR_W` = 12 and the default four beats. With a 12-bit address, distinct patterns in the upper bits can be loaded and tracked across every beat. The bench runs all four starting offsets in both orders. It inserts idle cycles between advances and flips `mode_i` in the middle of each burst, so a wrong order, a lost hold or mode leaking in after the load would each show up. Load-versus-advance collisions and advancing through the wrap are driven explicitly.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEATS = 4,
  localparam int CNT_W = $clog2(BEATS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BEATS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= '0;
    else if (adv_i)  cnt_q <= cnt_q + CNT_W'(1); // power-of-two wrap
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CNT_LAST);
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int ADDR_W = 20
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      mode_i,
  input  logic [ADDR_W-1:0]         addr_i,
  output logic [ADDR_W-1:0]         start_o,
  output burst_pkg::burst_order_e   order_o
);
  logic [ADDR_W-1:0]       start_q;
  burst_pkg::burst_order_e order_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      order_q <= burst_pkg::ORD_LINEAR;
    end else if (load_i) begin
      start_q <= addr_i;
      order_q <= burst_pkg::burst_order_e'(mode_i);
    end
  end

  assign start_o = start_q;
  assign order_o = order_q;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int BEATS = 4,
  localparam int LOW_W = $clog2(BEATS)
) (
  input  logic [LOW_W-1:0]        start_i,
  input  logic [LOW_W-1:0]        cnt_i,
  input  burst_pkg::burst_order_e order_i,
  output logic [LOW_W-1:0]        low_o
);
  logic [LOW_W-1:0] lin_low;
  logic [LOW_W-1:0] ilv_low;

  assign lin_low = start_i + cnt_i;

  // interleaved: per-bit xor of offset and beat count
  for (genvar b = 0; b < LOW_W; b++) begin : g_ilv
    assign ilv_low[b] = start_i[b] ^ cnt_i[b];
  end

  assign low_o = (order_i == burst_pkg::ORD_INTERLEAVE) ? ilv_low : lin_low;
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top #(
  parameter int ADDR_W = 20,
  parameter int BEATS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int LOW_W = $clog2(BEATS);

  logic [ADDR_W-1:0]       start_q;
  burst_pkg::burst_order_e order_q;
  logic [LOW_W-1:0]        cnt;
  logic [LOW_W-1:0]        low;

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .mode_i  (mode_i),
    .addr_i  (addr_i),
    .start_o (start_q),
    .order_o (order_q)
  );

  burst_beat_ctr #(.BEATS(BEATS)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .adv_i  (adv_i),
    .cnt_o  (cnt),
    .last_o (last_o)
  );

  burst_order_map #(.BEATS(BEATS)) u_map (
    .start_i (start_q[LOW_W-1:0]),
    .cnt_i   (cnt),
    .order_i (order_q),
    .low_o   (low)
  );

  assign addr_o = {start_q[ADDR_W-1:LOW_W], low};
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int BEATS  = 4,
  localparam int LOW_W = $clog2(BEATS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              adv_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              last_o,
  input logic              order_q
);
  AST_LOAD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o == $past(addr_i)) && !last_o); // R2

  AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i && !order_q)
      |=> addr_o[LOW_W-1:0] == LOW_W'($past(addr_o[LOW_W-1:0]) + LOW_W'(1))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(addr_o) && $stable(last_o)); // R6

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && adv_i) |=> !last_o); // R7

  AST_WRAP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && adv_i && !load_i) |=> !last_o); // R8

  AST_UPPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> addr_o[ADDR_W-1:LOW_W] == $past(addr_o[ADDR_W-1:LOW_W])); // R9
endmodule

bind burst_seq_top burst_seq_chk #(.ADDR_W(ADDR_W), .BEATS(BEATS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .adv_i   (adv_i),
  .addr_i  (addr_i),
  .addr_o  (addr_o),
  .last_o  (last_o),
  .order_q (order_q)
);

// File: tb/burst_seq_top_test.sv
module burst_seq_top_test;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic          adv = 1'b0;
  logic          mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] addr_q;
  logic          last_q;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  burst_seq_top #(.ADDR_W(AW), .BEATS(4)) uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .load_i (load),
    .adv_i  (adv),
    .mode_i (mode),
    .addr_i (addr),
    .addr_o (addr_q),
    .last_o (last_q)
  );

  function automatic logic [1:0] ref_low(input logic [1:0] s, input logic il, input int n);
    logic [1:0] k;
    k = n[1:0];
    return il ? (s ^ k) : (s + k);
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic l, input logic a, input logic m, input logic [AW-1:0] ad);
    @(negedge clk);
    load = l; adv = a; mode = m; addr = ad;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 addr", addr_q, '0);
    chk("R1 last", {{(AW-1){1'b0}}, last_q}, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 addr after release", addr_q, '0);
    chk("R1 last after release", {{(AW-1){1'b0}}, last_q}, '0);
  endtask

  // mode flipped on every non-load cycle to check R5 alongside R3/R4
  task automatic t_burst(input logic [1:0] s, input logic il, input logic [AW-3:0] up);
    logic [AW-1:0] exp;
    step(1'b1, 1'b0, il, {up, s});
    chk("R2 load addr", addr_q, {up, s});
    chk("R2 load last", {{(AW-1){1'b0}}, last_q}, '0);
    for (int n = 1; n <= 5; n++) begin
      step(1'b0, 1'b0, ~il, ~{up, s});
      exp = {up, ref_low(s, il, n - 1)};
      chk("R6 idle hold", addr_q, exp);
      step(1'b0, 1'b1, ~il, ~{up, s});
      exp = {up, ref_low(s, il, n)};
      chk(il ? "R4 R5 R9 interleaved beat" : "R3 R5 R9 linear beat", addr_q, exp);
      chk("R8 last flag", {{(AW-1){1'b0}}, last_q}, {{(AW-1){1'b0}}, ((n % 4) == 3)});
    end
  endtask

  task automatic t_load_priority();
    step(1'b1, 1'b0, 1'b0, 12'hA51);
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b1, 1'b1, 1'b1, 12'h3C6);
    chk("R7 load over adv addr", addr_q, 12'h3C6);
    chk("R7 load over adv last", {{(AW-1){1'b0}}, last_q}, '0);
    step(1'b0, 1'b1, 1'b0, '0);
    chk("R7 R4 next beat interleaved", addr_q, 12'h3C7);
  endtask

  task automatic t_wrap_last();
    step(1'b1, 1'b0, 1'b0, 12'hFF3);
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b1, 1'b0, '0);
    chk("R8 not last after two", {{(AW-1){1'b0}}, last_q}, '0);
    step(1'b0, 1'b1, 1'b0, '0);
    chk("R8 last after three", {{(AW-1){1'b0}}, last_q}, 12'd1);
    chk("R3 third beat", addr_q, 12'hFF2);
    step(1'b0, 1'b1, 1'b0, '0);
    chk("R8 wrap to start", addr_q, 12'hFF3);
    chk("R8 last cleared", {{(AW-1){1'b0}}, last_q}, '0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        t_burst(s[1:0], m[0], 10'(10'h2A5 ^ (s * 37 + m * 101)));
    t_load_priority();
    t_wrap_last();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule